// File: doc/BRIEF.md
# Two-Channel Uneven-Capacity Address Mapper

This block turns a system byte address into a DRAM channel port number and an address local to that channel, for a memory system with two channels whose populated capacities may differ. The lower part of the address space is spread across both channels one 64-byte line at a time, which doubles bandwidth for the common case. Memory that only the larger channel holds sits above that region and is reached linearly. Both regions are usable at the same time.

Capacities are programmed in units of 2^GRAN_LG2 bytes, 1 MiB by default. Channel "A" is the larger logical channel and must be programmed no smaller than "B". A swap input chooses which physical port each logical channel drives. An empty B channel gives plain single-channel operation, and equal capacities make the whole space interleaved. Addresses at or beyond installed memory, and any request under an illegal configuration, return an error and no channel request. The mapping is computed combinationally and presented through one register stage.

Top module: `dual_chan_map`

## Requirements
- R1: When the address is below 2*sizeB*2^GRAN_LG2, the logical channel is address bit 6 (0 selects A, 1 selects B). The local address is the address with bit 6 removed, i.e. {addr[ADDR_W-1:7], addr[5:0]} zero-extended.
- R2: When the address is at or above 2*sizeB*2^GRAN_LG2 and below the total, logical channel A is used and the local address is addr - sizeB*2^GRAN_LG2.
- R3: When the address is at or above (sizeA+sizeB)*2^GRAN_LG2, outErr is 1 and outValid is 0.
- R4: If sizeB > sizeA, every request returns outErr=1 and outValid=0, whatever the address.
- R5: The physical port is the logical channel XOR swapMap: with swapMap=0, A drives port 0 and B drives port 1. With swapMap=1 the mapping is reversed.
- R6: With sizeB=0 and sizeA>0, every in-range address goes to A with local address equal to the address.
- R7: With sizeA=sizeB, every in-range address follows R1, so the channels alternate on each 64-byte line.
- R8: The result of a request appears on the outputs exactly one clock after reqValid is sampled high. A cycle without a request gives outValid=0 and outErr=0 on the next cycle.
- R9: While rstN is low, and on the first cycle after reset, outValid, outErr, outChan and outAddr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | System byte address |
| sizeA | input | SIZE_W | Capacity of logical channel A, in 2^GRAN_LG2-byte units |
| sizeB | input | SIZE_W | Capacity of logical channel B, in 2^GRAN_LG2-byte units |
| swapMap | input | 1 | 0: A on port 0, B on port 1; 1: reversed |
| outValid | output | 1 | Registered channel request |
| outErr | output | 1 | Registered error: address out of range or illegal configuration |
| outChan | output | 1 | Physical port of the request |
| outAddr | output | ADDR_W | Channel-local byte address |

## Verification
The checker watches the properties that hold on every cycle: valid and error are never raised together, results follow requests one clock later, idle cycles give quiet outputs, an illegal configuration always gives an error, a single-channel setup always selects A's port, and a returned local address never exceeds the larger channel's capacity. The exact local address values, the alternation of lines across the interleave boundary, the change-over from interleaved to linear at twice B's capacity, and the effect of the swap on each zone are shown only by the bench. The bench compares random and directed addresses against its own mapping function for asymmetric, equal, single-channel, swapped and illegal configurations.

// File: rtl/dual_chan_map_pkg.sv
package dual_chan_map_pkg;
  // Strobes from the zone decoder to the address datapath.
  typedef struct packed {
    logic take;    // issue a channel request
    logic flag;    // report an error
    logic ilv;     // address lies in the interleaved zone
    logic logicB;  // logical channel B chosen
  } mapStrobe_t;
endpackage

// File: rtl/dual_chan_map_ctrl.sv
module dual_chan_map_ctrl
  import dual_chan_map_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int SIZE_W   = 13,
  parameter int GRAN_LG2 = 20,
  parameter int LINE_LG2 = 6
) (
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] sizeA,
  input  logic [SIZE_W-1:0] sizeB,
  output mapStrobe_t        strobes
);
  localparam int EXT_W = ADDR_W + 2;

  logic [EXT_W-1:0] addrExt;
  logic [EXT_W-1:0] ilvTop;
  logic [EXT_W-1:0] totalTop;
  logic             cfgBad;
  logic             rangeBad;
  logic             inIlv;

  always_comb begin
    addrExt  = EXT_W'(reqAddr);
    ilvTop   = EXT_W'(sizeB) << (GRAN_LG2 + 1);
    totalTop = (EXT_W'(sizeA) + EXT_W'(sizeB)) << GRAN_LG2;
    cfgBad   = sizeB > sizeA;
    rangeBad = addrExt >= totalTop;
    inIlv    = addrExt < ilvTop;

    strobes.take   = reqValid & ~cfgBad & ~rangeBad;
    strobes.flag   = reqValid & (cfgBad | rangeBad);
    strobes.ilv    = inIlv;
    strobes.logicB = inIlv & reqAddr[LINE_LG2];
  end
endmodule

// File: rtl/dual_chan_map_dp.sv
module dual_chan_map_dp
  import dual_chan_map_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int SIZE_W   = 13,
  parameter int GRAN_LG2 = 20,
  parameter int LINE_LG2 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] sizeB,
  input  logic              swapMap,
  input  mapStrobe_t        strobes,
  output logic              outValid,
  output logic              outErr,
  output logic              outChan,
  output logic [ADDR_W-1:0] outAddr
);
  localparam int UPPER_W = ADDR_W - LINE_LG2 - 1;

  logic [ADDR_W-1:0] bBytes;
  logic [ADDR_W-1:0] ilvLocal;
  logic [ADDR_W-1:0] linLocal;
  logic [ADDR_W-1:0] nextAddr;
  logic              nextChan;

  always_comb begin
    bBytes   = ADDR_W'(sizeB) << GRAN_LG2;
    ilvLocal = {1'b0, reqAddr[ADDR_W-1 -: UPPER_W], reqAddr[LINE_LG2-1:0]};
    linLocal = reqAddr - bBytes;
    nextAddr = strobes.ilv ? ilvLocal : linLocal;
    nextChan = strobes.logicB ^ swapMap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outErr   <= 1'b0;
      outChan  <= 1'b0;
      outAddr  <= '0;
    end else begin
      outValid <= strobes.take;
      outErr   <= strobes.flag;
      outChan  <= strobes.take ? nextChan : 1'b0;
      outAddr  <= strobes.take ? nextAddr : '0;
    end
  end
endmodule

// File: rtl/dual_chan_map.sv
module dual_chan_map
  import dual_chan_map_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int SIZE_W   = 13,
  parameter int GRAN_LG2 = 20,
  parameter int LINE_LG2 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] sizeA,
  input  logic [SIZE_W-1:0] sizeB,
  input  logic              swapMap,
  output logic              outValid,
  output logic              outErr,
  output logic              outChan,
  output logic [ADDR_W-1:0] outAddr
);
  mapStrobe_t strobes;

  dual_chan_map_ctrl #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .GRAN_LG2(GRAN_LG2), .LINE_LG2(LINE_LG2)
  ) ctrl_i (
    .reqValid(reqValid),
    .reqAddr (reqAddr),
    .sizeA   (sizeA),
    .sizeB   (sizeB),
    .strobes (strobes)
  );

  dual_chan_map_dp #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .GRAN_LG2(GRAN_LG2), .LINE_LG2(LINE_LG2)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqAddr (reqAddr),
    .sizeB   (sizeB),
    .swapMap (swapMap),
    .strobes (strobes),
    .outValid(outValid),
    .outErr  (outErr),
    .outChan (outChan),
    .outAddr (outAddr)
  );
endmodule

// File: rtl/dual_chan_map_chk.sv
module dual_chan_map_chk #(
  parameter int ADDR_W   = 34,
  parameter int SIZE_W   = 13,
  parameter int GRAN_LG2 = 20,
  parameter int LINE_LG2 = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [SIZE_W-1:0] sizeA,
  input logic [SIZE_W-1:0] sizeB,
  input logic              swapMap,
  input logic              outValid,
  input logic              outErr,
  input logic              outChan,
  input logic [ADDR_W-1:0] outAddr
);
  localparam int EXT_W = ADDR_W + 2;

  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outErr)); // R3

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (outValid || outErr)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && !outErr)); // R8

  AST_BAD_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (sizeB > sizeA)) |=> (outErr && !outValid)); // R4

  AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sizeB == '0) |=> (!outValid || outChan == $past(swapMap))); // R6

  AST_LOCAL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (!outValid ||
      (EXT_W'(outAddr) < (EXT_W'($past(sizeA)) << GRAN_LG2)))); // R2
endmodule

bind dual_chan_map dual_chan_map_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .GRAN_LG2(GRAN_LG2), .LINE_LG2(LINE_LG2)
) chk_i (.*);

// File: tb/dual_chan_map_tb_top.sv
module dual_chan_map_tb_top;
  localparam int ADDR_W   = 34;
  localparam int SIZE_W   = 13;
  localparam int GRAN_LG2 = 20;
  localparam longint GRAN = longint'(1) << GRAN_LG2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [SIZE_W-1:0] sizeA = '0;
  logic [SIZE_W-1:0] sizeB = '0;
  logic              swapMap = 1'b0;
  logic              outValid, outErr, outChan;
  logic [ADDR_W-1:0] outAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dual_chan_map #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .GRAN_LG2(GRAN_LG2)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .sizeA(sizeA), .sizeB(sizeB), .swapMap(swapMap),
    .outValid(outValid), .outErr(outErr), .outChan(outChan), .outAddr(outAddr)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference mapping built from the requirements.
  function automatic void model(input longint a, input int sA, input int sB, input bit sw,
                                output bit err, output bit ch, output longint loc);
    longint total = longint'(sA + sB) * GRAN;
    longint ilvTop = 2 * longint'(sB) * GRAN;
    err = 1'b0; ch = 1'b0; loc = 0;
    if (sB > sA || a >= total) err = 1'b1;
    else if (a < ilvTop) begin
      ch  = bit'((a >> 6) & 1) ^ sw;
      loc = ((a >> 7) << 6) | (a & 63);
    end else begin
      ch  = sw;
      loc = a - longint'(sB) * GRAN;
    end
  endfunction

  task automatic apply(input string tag, input longint a);
    bit eErr, eCh; longint eLoc;
    model(a, int'(sizeA), int'(sizeB), swapMap, eErr, eCh, eLoc);
    reqAddr  = ADDR_W'(a);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " err"}, longint'(outErr), longint'(eErr));
    check({tag, " valid"}, longint'(outValid), longint'(!eErr));
    if (!eErr) begin
      check({tag, " chan"}, longint'(outChan), longint'(eCh));
      check({tag, " addr"}, longint'(outAddr), eLoc);
    end
  endtask

  task automatic setCfg(input int a, input int b, input bit sw);
    sizeA = SIZE_W'(a); sizeB = SIZE_W'(b); swapMap = sw;
  endtask

  task automatic randomRun(input string tag, input int n);
    longint span = longint'(int'(sizeA) + int'(sizeB)) * GRAN;
    for (int i = 0; i < n; i++) begin
      longint r = {$urandom(), $urandom()} & 64'h7FFF_FFFF_FFFF_FFFF;
      longint lim = span + span / 8 + 1;
      apply(tag, r % lim);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", longint'(outValid), 0);
    check("R9 err",   longint'(outErr), 0);
    check("R9 addr",  longint'(outAddr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 post chan", longint'(outChan), 0);

    // Asymmetric: A=3072 MiB, B=1024 MiB
    setCfg(3072, 1024, 1'b0);
    apply("R1 zero", 0);
    apply("R1 line1", 64);
    apply("R1 line2", 128 + 5);
    apply("R1 ilv last", 2 * 1024 * GRAN - 1);
    apply("R2 ilv edge", 2 * 1024 * GRAN);
    apply("R2 top-1", 4096 * GRAN - 1);
    apply("R3 total", 4096 * GRAN);
    apply("R3 max", (longint'(1) << ADDR_W) - 1);
    randomRun("R1R2 asym", 300);
    // R8: idle cycle gives quiet outputs
    @(negedge clk);
    check("R8 idle valid", longint'(outValid), 0);
    check("R8 idle err", longint'(outErr), 0);

    // R5: swapped ports
    setCfg(3072, 1024, 1'b1);
    apply("R5 ilv A", 0);
    apply("R5 ilv B", 64);
    apply("R5 high", 3000 * GRAN);
    randomRun("R5 swap", 200);

    // R7: equal sizes
    setCfg(2048, 2048, 1'b0);
    apply("R7 low", 192);
    apply("R7 top-1", 4096 * GRAN - 1);
    apply("R7 top", 4096 * GRAN);
    randomRun("R7 equal", 200);

    // R6: single channel
    setCfg(1500, 0, 1'b0);
    apply("R6 line1", 64);
    apply("R6 mid", 777 * GRAN + 99);
    apply("R6 end", 1500 * GRAN);
    setCfg(1500, 0, 1'b1);
    randomRun("R6 single", 200);

    // R4: illegal configuration
    setCfg(512, 1024, 1'b0);
    apply("R4 zero", 0);
    apply("R4 mid", 300 * GRAN);
    randomRun("R4 badcfg", 50);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule